// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Enable Register

This block is the interrupt control and status word of an I2C master controller. It keeps eight sticky event flags, one per condition reported by the bus engine: bus free, data engine complete, no slave acknowledge, oversize transfer terminated, early termination, master arbitration loss, slave stop and slave. Each flag has an enable bit. The block drives one registered, level interrupt line, which is high while any enabled flag is set.

Software reaches the word through a simple write-strobe register bus at three addresses, all of which read back the same value. The plain view loads bits directly. The set view turns on every bit written as 1. The clear view turns off every bit written as 1. In the set and clear views, bits written as 0 keep their value. A further control bit tells a bus engine that has halted on a NAK to go back to idle. Writing it as 1 produces exactly one pulse to the engine, and the bit then clears itself.

Event pulses from the engine always take priority over software clears in the same cycle, so no event is lost while an interrupt handler acknowledges other flags. The event inputs and the NAK-release pulse are plain control pins with no handshake.

Top module: `i2c_irq_csr`

## Requirements
- R1: While reset is asserted and just after it, all flags, all enables, the NAK-release bit, `irq_o`, `nak_clr_o` and `rdata` are 0.
- R2: The read layout is as follows. Flags sit in bits 7..0: 7 bus free, 6 data complete, 5 no acknowledge, 4 oversize, 3 early termination, 2 arbitration loss, 1 slave stop, 0 slave. The enable for flag n is bit n+8. Bit 28 is the NAK-release bit. Every other bit reads 0, whatever was written to it.
- R3: A write at offset 0x0 loads bits 15..0 from `wdata`. Each bit takes the value written to it.
- R4: A write at offset 0x4 sets every bit of 15..0 that is written as 1 and leaves the bits written as 0 unchanged.
- R5: A write at offset 0x8 clears every bit of 15..0 that is written as 1 and leaves the bits written as 0 unchanged.
- R6: A one-cycle pulse on `evt_i[n]` sets flag n whatever its enable is. The flag then stays set until software removes it.
- R7: If `evt_i[n]` is high in the same cycle as a write that would clear flag n (clear view or plain view), the flag ends up set.
- R8: `irq_o` is registered. In each cycle it equals the OR, over n, of flag n AND enable n as they stood one cycle earlier.
- R9: A write with bit 28 set, at offset 0x0 or 0x4, makes bit 28 read 1 and `nak_clr_o` high for exactly the next cycle, then both return to 0. Bit 28 written at offset 0x8 produces no pulse.
- R10: A write to any offset other than 0x0, 0x4 or 0x8 changes no state.
- R11: `rdata` is combinational on `addr`. It returns the same word at offsets 0x0, 0x4 and 0x8, and 0 at any other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 4 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| evt_i | input | 8 | Event pulses from the bus engine, one per flag |
| irq_o | output | 1 | Registered interrupt level |
| nak_clr_o | output | 1 | One-cycle pulse that releases a NAK-halted engine |

## Verification
The assertions take for granted that `evt_i`, `wr_en`, `addr` and `wdata` are driven from the clock domain of the block and are stable around the edge. They also assume that a flag can change only through an event or a write strobe, which holds when `wr_en` is low on idle cycles. The bench drives every input on the falling edge and lowers `wr_en` and `evt_i` after each operation. It then reads at offset 0x0 half a cycle later, so every transition the assertions relate is produced by exactly one strobe.

// File: rtl/i2c_irq_csr_pkg.sv
package i2c_irq_csr_pkg;
  typedef enum logic [1:0] {
    VIEW_NONE  = 2'd0,
    VIEW_PLAIN = 2'd1,
    VIEW_SET   = 2'd2,
    VIEW_CLR   = 2'd3
  } view_e;
endpackage

// File: rtl/csr_view_decode.sv
module csr_view_decode
  import i2c_irq_csr_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int OFF_PLAIN = 0,
  parameter int OFF_SET   = 4,
  parameter int OFF_CLR   = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output view_e             view,
  output logic              rd_hit
);
  localparam logic [ADDR_W-1:0] A_PLAIN = ADDR_W'(OFF_PLAIN);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFF_CLR);

  always_comb begin
    rd_hit = (addr == A_PLAIN) || (addr == A_SET) || (addr == A_CLR);
    view   = VIEW_NONE;
    if (wr_en) begin
      if (addr == A_PLAIN)      view = VIEW_PLAIN;
      else if (addr == A_SET)   view = VIEW_SET;
      else if (addr == A_CLR)   view = VIEW_CLR;
    end
  end
endmodule

// File: rtl/csr_bit_bank.sv
module csr_bit_bank
  import i2c_irq_csr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  view_e        view,
  input  logic [W-1:0] wbits,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic nxt;
    always_comb begin
      unique case (view)
        VIEW_PLAIN: nxt = wbits[i];
        VIEW_SET:   nxt = q[i] | wbits[i];
        VIEW_CLR:   nxt = q[i] & ~wbits[i];
        default:    nxt = q[i];
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= nxt | evt[i];
    end

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> q[i]); // R7
    AST_NO_SPURIOUS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q[i]) |-> ($past(evt[i]) || $past(view == VIEW_PLAIN) || $past(view == VIEW_SET))); // R6
    AST_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(q[i]) |-> (!$past(evt[i]) && ($past(view == VIEW_PLAIN) || $past(view == VIEW_CLR)))); // R5
  end
endmodule

// File: rtl/irq_reduce.sv
module irq_reduce #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] enables,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flags & enables);
  end
endmodule

// File: rtl/i2c_irq_csr.sv
module i2c_irq_csr
  import i2c_irq_csr_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int N_FLAGS = 8,
  parameter int NAK_BIT = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_FLAGS-1:0] evt_i,
  output logic              irq_o,
  output logic              nak_clr_o
);
  localparam int EN_LO = N_FLAGS;
  localparam int EN_HI = 2 * N_FLAGS - 1;

  view_e              view;
  logic               rd_hit;
  logic [N_FLAGS-1:0] flag_q;
  logic [N_FLAGS-1:0] en_q;
  logic               nak_q;
  logic               nak_req;
  logic               unused_wbits;

  assign unused_wbits = ^{wdata[DATA_W-1:NAK_BIT+1], wdata[NAK_BIT-1:EN_HI+1]};

  csr_view_decode #(.ADDR_W(ADDR_W), .OFF_PLAIN(0), .OFF_SET(4), .OFF_CLR(8)) u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .view  (view),
    .rd_hit(rd_hit)
  );

  csr_bit_bank #(.W(N_FLAGS)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .view (view),
    .wbits(wdata[N_FLAGS-1:0]),
    .evt  (evt_i),
    .q    (flag_q)
  );

  csr_bit_bank #(.W(N_FLAGS)) u_enables (
    .clk  (clk),
    .rst_n(rst_n),
    .view (view),
    .wbits(wdata[EN_HI:EN_LO]),
    .evt  ('0),
    .q    (en_q)
  );

  irq_reduce #(.W(N_FLAGS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .flags  (flag_q),
    .enables(en_q),
    .irq    (irq_o)
  );

  assign nak_req = wdata[NAK_BIT] && ((view == VIEW_PLAIN) || (view == VIEW_SET));

  always_ff @(posedge clk) begin
    if (!rst_n) nak_q <= 1'b0;
    else        nak_q <= nak_req;
  end

  assign nak_clr_o = nak_q;

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      rdata[N_FLAGS-1:0] = flag_q;
      rdata[EN_HI:EN_LO] = en_q;
      rdata[NAK_BIT]     = nak_q;
    end
  end

  AST_NAK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_clr_o && !(wr_en && wdata[NAK_BIT] && (addr == ADDR_W'(0) || addr == ADDR_W'(4))))
      |=> !nak_clr_o); // R9
  AST_NAK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nak_clr_o) |-> $past(wr_en)); // R9
  AST_IRQ_DROP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(wr_en, 2)); // R8
endmodule

// File: tb/i2c_irq_csr_tb.sv
`timescale 1ns/1ps
module i2c_irq_csr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  evt_i = '0;
  logic        irq_o;
  logic        nak_clr_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_irq_csr u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_i(evt_i), .irq_o(irq_o), .nak_clr_o(nak_clr_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operation, then check the word, the pulse and the irq timing.
  task automatic op(input bit we, input logic [3:0] a, input logic [31:0] d,
                    input logic [7:0] ev, input string req);
    logic old_irq;
    logic nakx;
    logic [31:0] expw;
    old_irq = |(m[7:0] & m[15:8]);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; evt_i = ev;
    @(negedge clk);
    wr_en = 1'b0; addr = 4'h0; wdata = '0; evt_i = '0;
    if (we) begin
      case (a)
        4'h0: m = d[15:0];
        4'h4: m = m | d[15:0];
        4'h8: m = m & ~d[15:0];
        default: ;
      endcase
    end
    m[7:0] = m[7:0] | ev;
    nakx = we && d[28] && (a == 4'h0 || a == 4'h4);
    expw = {3'b0, nakx, 12'b0, m};
    #0.5;
    chk(rdata == expw, req, rdata, expw);
    chk(nak_clr_o == nakx, "R9 pulse", {31'b0, nak_clr_o}, {31'b0, nakx});
    chk(irq_o == old_irq, "R8 delay", {31'b0, irq_o}, {31'b0, old_irq});
    @(negedge clk);
    #0.5;
    chk(irq_o == |(m[7:0] & m[15:8]), "R8 level", {31'b0, irq_o}, {31'b0, |(m[7:0] & m[15:8])});
    chk(nak_clr_o == 1'b0 && rdata[28] == 1'b0, "R9 self-clear", rdata, {3'b0, 1'b0, 12'b0, m});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    chk(rdata == 32'h0 && !irq_o && !nak_clr_o, "R1 in reset", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #0.5;
    chk(rdata == 32'h0 && !irq_o && !nak_clr_o, "R1 after reset", rdata, 32'h0);

    // R3 / R2: plain loads of every flag pattern with varied enables
    for (int p = 0; p < 256; p++)
      op(1'b1, 4'h0, {16'hFFFF, 8'((p * 37 + 11) % 256), 8'(p)}, 8'h00, "R3 plain");

    // Per-bit sweep: event, enable, collision, clear
    for (int i = 0; i < 8; i++) begin
      op(1'b1, 4'h0, 32'h0, 8'h00, "R3 zero");
      op(1'b0, 4'h0, 32'h0, 8'(1 << i), "R6 event sets");
      op(1'b1, 4'h4, 32'(1 << ((i + 1) % 8 + 8)), 8'h00, "R4 other enable");
      op(1'b1, 4'h4, 32'(1 << (i + 8)), 8'h00, "R4 own enable");
      op(1'b1, 4'h8, 32'(1 << i), 8'(1 << i), "R7 event beats clear");
      op(1'b1, 4'h8, 32'(1 << i), 8'h00, "R5 clear");
      op(1'b1, 4'h0, 32'h0000FF00, 8'(1 << i), "R7 event beats plain");
    end

    // Set and clear aliases with mixed patterns
    for (int p = 0; p < 64; p++) begin
      op(1'b1, 4'h4, 32'((p * 1103 + 7) & 16'hFFFF), 8'h00, "R4 set alias");
      op(1'b1, 4'h8, 32'((p * 2221 + 3) & 16'hFFFF), 8'(p * 5), "R5 clear alias");
    end

    // NAK release
    op(1'b1, 4'h0, 32'h1000_0000, 8'h00, "R9 plain");
    op(1'b1, 4'h4, 32'h1000_00A5, 8'h00, "R9 set");
    op(1'b1, 4'h8, 32'h1000_0005, 8'h00, "R9 clear no pulse");
    op(1'b1, 4'h0, 32'hFFFF_FFFF, 8'h00, "R2 upper bits");

    // Unknown address and aliased reads
    op(1'b1, 4'hC, 32'h0000_0000, 8'h00, "R10 ignored");
    op(1'b1, 4'h2, 32'h1000_0000, 8'h00, "R10 ignored");
    @(negedge clk);
    addr = 4'h4; #0.5;
    chk(rdata == {16'h0, m}, "R11 set view read", rdata, {16'h0, m});
    addr = 4'h8; #0.5;
    chk(rdata == {16'h0, m}, "R11 clear view read", rdata, {16'h0, m});
    addr = 4'hC; #0.5;
    chk(rdata == 32'h0, "R11 other read", rdata, 32'h0);
    addr = 4'h0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule